// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a register-mapped watchdog that counts coarse ticks derived from the input clock through two chained phases. The first phase is an early warning. When it runs out, a sticky status bit is set and an interrupt line is raised, so software gets a last chance to kick the timer. If no kick arrives, the second phase runs out. The block then sets a second status bit and sends a one-cycle reset request, tagged with a reset type taken from the control register.

The tick length is a power of two: 2^(TICK_EXP + S) clock cycles, where S is a 2-bit scale field and TICK_EXP defaults to 25. Each phase lasts from 1 to 32 ticks. Software controls the block through three 32-bit word registers, selected by byte address with the low two address bits ignored:

| Offset | Register | Behaviour |
|---|---|---|
| 0x0 | kick | Write-only; reads 0 |
| 0x4 | status | Bits are cleared by writing a 1 to them |
| 0x8 | control | Configuration and enable |

Once the warning phase has fired, software can no longer turn the timer off, so a runaway program cannot cancel the pending reset.

Top module: `wdog_twophase`

## Requirements
- R1: After reset, the control register reads 0x0000_0001 (enabled off, reset type CPU). The status register reads 0. `warn_irq`, `phase2_flag` and `rst_req` are low.
- R2: The control word has these fields: enable at bit 31, scale S at bits 30:29, warning limit W at bits 26:22, reset limit P at bits 19:15, and reset type at bits 1:0. After the clock edge that captures a write setting enable, `warn_irq` rises after exactly 1 + (W+1)·2^(TICK_EXP+S) further clock edges.
- R3: Once the warning phase has fired, `rst_req` pulses high for exactly one cycle, (P+1)·2^(TICK_EXP+S) edges later. During that pulse `rst_kind` equals the reset type field (0 full chip, 1 CPU only, 2 software). `phase2_flag` is set at the same edge.
- R4: The status register shows the warning flag at bit 31 and the reset flag at bit 30. Each bit stays set until a write to offset 0x4 carries a 1 in that bit. Writing 0 to a bit leaves it unchanged. `warn_irq` and `phase2_flag` mirror these two bits.
- R5: A write to offset 0x0 with bit 31 set, while the timer runs, restarts the warning phase from zero ticks. The warning then fires (W+1)·2^(TICK_EXP+S) edges after the capturing edge. A write to offset 0x0 with bit 31 clear has no effect.
- R6: A kick during the reset phase returns the timer to the warning phase. No reset request is issued at the old deadline. The warning flag stays set.
- R7: Clearing enable before the warning fires stops and clears the counters. A kick while disabled has no effect. Setting enable again starts a full warning phase from zero.
- R8: While the reset phase runs, a control write with enable 0 still updates the other fields, but enable reads back 1 and the reset request still arrives on time.
- R9: The edge that issues the reset request also clears enable. No further warning or reset events follow until enable is set again.
- R10: Reserved control bits and reads of any offset other than 0x4 and 0x8 return 0. Every control field reads back the value last written.
- R11: A limit value of 0 gives a phase of exactly one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| warn_irq | output | 1 | Warning interrupt (status bit 31) |
| phase2_flag | output | 1 | Reset phase expired (status bit 30) |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | 2 | Reset type, valid while `rst_req` is high |

## Verification
The hardest state to reach from the ports is the reset phase with its lock active. Only there does a disable write get overridden, and only there does a kick have to pull the timer back into the warning phase. The stimulus waits for the warning interrupt and then issues a disable write or a kick on the very next cycle. It then counts edges to the new deadline, using a shortened tick exponent. A behavioural model, driven only by deadlines computed from the field values, is compared with every output and every read on each cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int REG_W   = 32;
  localparam int PRE_W   = 2;
  localparam int PHASE_W = 5;
  localparam int MODE_W  = 2;

  // control word layout
  localparam int EN_BIT   = 31;
  localparam int PRE_LSB  = 29;
  localparam int PH1_LSB  = 22;
  localparam int PH2_LSB  = 15;
  localparam int MODE_LSB = 0;

  // status and kick bits
  localparam int ST_WARN_BIT = 31;
  localparam int ST_RST_BIT  = 30;
  localparam int KICK_BIT    = 31;

  // word selects
  localparam logic [1:0] SEL_KICK = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  localparam logic [MODE_W-1:0] MODE_CPU = 2'd1;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WARN  = 2'd1,
    PH_RESET = 2'd2
  } phase_e;

  typedef struct packed {
    logic               enable;
    logic [PRE_W-1:0]   prescale;
    logic [PHASE_W-1:0] warn_lim;
    logic [PHASE_W-1:0] reset_lim;
    logic [MODE_W-1:0]  mode;
  } ctrl_t;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen
  import wdt_pkg::*;
#(
  parameter int TICK_EXP = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);

  localparam int PMAX  = (1 << PRE_W) - 1;
  localparam int CNT_W = TICK_EXP + PMAX;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;
  logic             cnt_en;

  // limit = 2^(TICK_EXP+prescale) - 1
  always_comb begin
    limit = {CNT_W{1'b1}} >> (PMAX - int'(prescale));
  end

  always_comb begin
    tick   = run && (cnt_q >= limit);
    cnt_en = run || (cnt_q != '0);
    if (!run || restart || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R5
  restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

endmodule

// File: rtl/wdt_phase_seq.sv
module wdt_phase_seq
  import wdt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               tick,
  input  logic               kick_req,
  input  logic [PHASE_W-1:0] warn_lim,
  input  logic [PHASE_W-1:0] reset_lim,
  input  logic [MODE_W-1:0]  mode,
  output phase_e             state,
  output logic               restart,
  output logic               fire_warn,
  output logic               fire_reset,
  output logic               rst_pulse,
  output logic [MODE_W-1:0]  rst_kind
);

  phase_e             state_q, state_d;
  logic [PHASE_W-1:0] cnt_q, cnt_d;
  logic               pulse_q;
  logic [MODE_W-1:0]  kind_q, kind_d;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    fire_warn  = 1'b0;
    fire_reset = 1'b0;
    restart    = kick_req && (state_q != PH_IDLE);
    unique case (state_q)
      PH_IDLE: begin
        if (enable) begin
          state_d = PH_WARN;
          cnt_d   = '0;
        end
      end
      PH_WARN: begin
        if (restart) begin
          cnt_d = '0;
        end else if (!enable) begin
          state_d = PH_IDLE;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt_q >= warn_lim) begin
            fire_warn = 1'b1;
            state_d   = PH_RESET;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + PHASE_W'(1);
          end
        end
      end
      PH_RESET: begin
        if (restart) begin
          state_d = PH_WARN;
          cnt_d   = '0;
        end else if (tick) begin
          if (cnt_q >= reset_lim) begin
            fire_reset = 1'b1;
            state_d    = PH_IDLE;
            cnt_d      = '0;
          end else begin
            cnt_d = cnt_q + PHASE_W'(1);
          end
        end
      end
      default: begin
        state_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
    kind_d = fire_reset ? mode : kind_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      kind_q  <= MODE_CPU;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pulse_q <= fire_reset;
      kind_q  <= kind_d;
    end
  end

  assign state     = state_q;
  assign rst_pulse = pulse_q;
  assign rst_kind  = kind_q;

  // R3
  rst_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R5
  kick_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (state_q == PH_WARN) && (cnt_q == '0));

  // R9
  reset_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (state_q == PH_IDLE));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             locked,
  input  logic             fire_warn,
  input  logic             fire_reset,
  output ctrl_t            ctrl,
  output logic             st_warn,
  output logic             st_reset,
  output logic             kick_req,
  output logic [REG_W-1:0] rdata
);

  ctrl_t ctrl_q, ctrl_d;
  logic  st_warn_q, st_warn_d;
  logic  st_reset_q, st_reset_d;
  logic  ctrl_wr, stat_wr;
  logic  clr_warn, clr_reset;

  always_comb begin
    ctrl_wr   = wr_en && (sel == SEL_CTRL);
    stat_wr   = wr_en && (sel == SEL_STAT);
    kick_req  = wr_en && (sel == SEL_KICK) && wdata[KICK_BIT];
    clr_warn  = stat_wr && wdata[ST_WARN_BIT];
    clr_reset = stat_wr && wdata[ST_RST_BIT];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d.prescale  = wdata[PRE_LSB +: PRE_W];
      ctrl_d.warn_lim  = wdata[PH1_LSB +: PHASE_W];
      ctrl_d.reset_lim = wdata[PH2_LSB +: PHASE_W];
      ctrl_d.mode      = wdata[MODE_LSB +: MODE_W];
      // enable stays on once the warning has fired
      ctrl_d.enable    = wdata[EN_BIT] || locked || fire_warn;
    end
    if (fire_reset) begin
      ctrl_d.enable = 1'b0;
    end
    st_warn_d  = fire_warn  || (st_warn_q  && !clr_warn);
    st_reset_d = fire_reset || (st_reset_q && !clr_reset);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '{enable: 1'b0, prescale: '0, warn_lim: '0,
                      reset_lim: '0, mode: MODE_CPU};
      st_warn_q  <= 1'b0;
      st_reset_q <= 1'b0;
    end else begin
      ctrl_q     <= ctrl_d;
      st_warn_q  <= st_warn_d;
      st_reset_q <= st_reset_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_STAT: begin
        rdata[ST_WARN_BIT] = st_warn_q;
        rdata[ST_RST_BIT]  = st_reset_q;
      end
      SEL_CTRL: begin
        rdata[EN_BIT]                 = ctrl_q.enable;
        rdata[PRE_LSB +: PRE_W]       = ctrl_q.prescale;
        rdata[PH1_LSB +: PHASE_W]     = ctrl_q.warn_lim;
        rdata[PH2_LSB +: PHASE_W]     = ctrl_q.reset_lim;
        rdata[MODE_LSB +: MODE_W]     = ctrl_q.mode;
      end
      default: rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign st_warn  = st_warn_q;
  assign st_reset = st_reset_q;

  // R8
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> ctrl_q.enable);

  // R4
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_warn_q && !clr_warn) |=> st_warn_q);

  // R4
  reset_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_reset_q && !clr_reset) |=> st_reset_q);

endmodule

// File: rtl/wdog_twophase.sv
module wdog_twophase
  import wdt_pkg::*;
#(
  parameter int TICK_EXP = 25,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              warn_irq,
  output logic              phase2_flag,
  output logic              rst_req,
  output logic [1:0]        rst_kind
);

  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0] word;
  logic [1:0]       sel;
  ctrl_t            ctrl;
  phase_e           state;
  logic             tick, restart, fire_warn, fire_reset, kick_req;
  logic             run;

  always_comb begin
    word = reg_addr[ADDR_W-1:2];
    sel  = (word > SEL_W'(2)) ? SEL_NONE : word[1:0];
    run  = (state != PH_IDLE);
  end

  wdt_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .sel        (sel),
    .wdata      (reg_wdata),
    .locked     (state == PH_RESET),
    .fire_warn  (fire_warn),
    .fire_reset (fire_reset),
    .ctrl       (ctrl),
    .st_warn    (warn_irq),
    .st_reset   (phase2_flag),
    .kick_req   (kick_req),
    .rdata      (reg_rdata)
  );

  wdt_tick_gen #(.TICK_EXP(TICK_EXP)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .restart  (restart),
    .prescale (ctrl.prescale),
    .tick     (tick)
  );

  wdt_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (ctrl.enable),
    .tick       (tick),
    .kick_req   (kick_req),
    .warn_lim   (ctrl.warn_lim),
    .reset_lim  (ctrl.reset_lim),
    .mode       (ctrl.mode),
    .state      (state),
    .restart    (restart),
    .fire_warn  (fire_warn),
    .fire_reset (fire_reset),
    .rst_pulse  (rst_req),
    .rst_kind   (rst_kind)
  );

  // R3
  req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> phase2_flag);

  // R9
  req_disables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !ctrl.enable);

  // R2
  warn_from_phase1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_irq) |-> ($past(state) == PH_WARN));

endmodule

// File: tb/wdog_twophase_test.sv
`timescale 1ns/1ps
module wdog_twophase_test;

  localparam int TEXP = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        warn_irq, phase2_flag, rst_req;
  logic [1:0]  rst_kind;

  always #2.5 clk = ~clk;

  wdog_twophase #(.TICK_EXP(TEXP), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .warn_irq(warn_irq),
    .phase2_flag(phase2_flag), .rst_req(rst_req), .rst_kind(rst_kind)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(bit en, bit [1:0] pre, bit [4:0] p1,
                                      bit [4:0] p2, bit [1:0] md);
    return {en, pre, 2'b00, p1, 2'b00, p2, 13'b0, md};
  endfunction

  // ---------------- behavioural reference model ----------------
  longint cyc;
  int     m_state;   // 0 off, 1 warning phase, 2 reset phase
  longint m_due;
  bit     m_en, m_st1, m_st2, m_req;
  bit [1:0] m_pre, m_mode, m_kind;
  bit [4:0] m_p1, m_p2;

  function automatic longint tick_len();
    return longint'(1) << (TEXP + m_pre);
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    bit f1, f2, kick;
    int os;
    if (!rst_n) begin
      cyc = 0; m_state = 0; m_due = 0; m_en = 0; m_st1 = 0; m_st2 = 0;
      m_req = 0; m_pre = 0; m_mode = 2'd1; m_kind = 2'd1; m_p1 = 0; m_p2 = 0;
    end else begin
      f1 = 0; f2 = 0;
      os = m_state;
      cyc++;
      kick = reg_wr && reg_addr[3:2] == 2'd0 && reg_wdata[31];
      m_req = 0;
      if (os == 0) begin
        if (m_en) begin m_state = 1; m_due = cyc + (m_p1 + 1) * tick_len(); end
      end else if (kick) begin
        m_state = 1; m_due = cyc + (m_p1 + 1) * tick_len();
      end else if (os == 1 && !m_en) begin
        m_state = 0;
      end else if (os == 1 && cyc == m_due) begin
        f1 = 1; m_state = 2; m_due = cyc + (m_p2 + 1) * tick_len();
      end else if (os == 2 && cyc == m_due) begin
        f2 = 1; m_state = 0; m_req = 1; m_kind = m_mode;
      end
      if (reg_wr && reg_addr[3:2] == 2'd2) begin
        m_pre = reg_wdata[30:29]; m_p1 = reg_wdata[26:22];
        m_p2 = reg_wdata[19:15]; m_mode = reg_wdata[1:0];
        m_en = reg_wdata[31] || (os == 2) || f1;
      end
      if (f2) m_en = 0;
      if (reg_wr && reg_addr[3:2] == 2'd1) begin
        if (reg_wdata[31]) m_st1 = 0;
        if (reg_wdata[30]) m_st2 = 0;
      end
      if (f1) m_st1 = 1;
      if (f2) m_st2 = 1;
    end
  end

  function automatic logic [31:0] model_read(logic [3:0] a);
    case (a[3:2])
      2'd1: return {m_st1, m_st2, 30'b0};
      2'd2: return cfg(m_en, m_pre, m_p1, m_p2, m_mode);
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      chk("R2", "model warn_irq", 32'(warn_irq), 32'(m_st1));
      chk("R3", "model phase2_flag", 32'(phase2_flag), 32'(m_st2));
      chk("R3", "model rst_req", 32'(rst_req), 32'(m_req));
      if (m_req) chk("R3", "model rst_kind", 32'(rst_kind), 32'(m_kind));
      chk("R10", "model rdata", reg_rdata, model_read(reg_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(logic [3:0] a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // sel 0: warn_irq, 1: rst_req. Output must be low after n-1 edges, high after n.
  task automatic expect_rise(string req, int n, int sel);
    repeat (n - 1) @(negedge clk);
    chk(req, "before edge", 32'(sel == 0 ? warn_irq : rst_req), 32'h0);
    @(negedge clk);
    chk(req, "at edge", 32'(sel == 0 ? warn_irq : rst_req), 32'h1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 4'h0; reg_wdata = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'h8, d); chk("R1", "ctrl after reset", d, 32'h0000_0001);
    rd(4'h4, d); chk("R1", "status after reset", d, 32'h0);
    chk("R1", "outputs after reset", {29'b0, warn_irq, phase2_flag, rst_req}, 32'h0);

    // R11 / R3 / R9: shortest phases, software reset type
    wr(4'h8, cfg(1, 0, 0, 0, 2));
    expect_rise("R11", 1 + 8, 0);
    expect_rise("R3", 8, 1);
    chk("R3", "rst_kind software", 32'(rst_kind), 32'd2);
    @(negedge clk);
    chk("R3", "pulse single cycle", 32'(rst_req), 32'h0);
    rd(4'h8, d); chk("R9", "enable cleared", d, cfg(0, 0, 0, 0, 2));
    chk("R3", "phase2_flag set", 32'(phase2_flag), 32'h1);
    repeat (40) @(negedge clk);
    chk("R9", "no event after reset", 32'(rst_req), 32'h0);

    // R4 write-one-to-clear
    wr(4'h4, 32'h0);
    rd(4'h4, d); chk("R4", "zero write keeps bits", d, 32'hC000_0000);
    wr(4'h4, 32'h8000_0000);
    chk("R4", "warn cleared", {30'b0, warn_irq, phase2_flag}, 32'h1);
    wr(4'h4, 32'h4000_0000);
    rd(4'h4, d); chk("R4", "both cleared", d, 32'h0);

    // R2 / R8: scale 2 (32-cycle tick), disable write during reset phase
    wr(4'h8, cfg(1, 2, 3, 4, 0));
    expect_rise("R2", 1 + 4 * 32, 0);
    wr(4'h8, cfg(0, 2, 3, 4, 0));
    rd(4'h8, d); chk("R8", "enable locked", d, cfg(1, 2, 3, 4, 0));
    expect_rise("R8", 5 * 32 - 1, 1);
    chk("R3", "rst_kind chip", 32'(rst_kind), 32'd0);
    wr(4'h4, 32'hC000_0000);

    // R5 / R6: ignored kick, then a kick in the reset phase
    wr(4'h8, cfg(1, 0, 5, 7, 1));
    repeat (10) @(negedge clk);
    wr(4'h0, 32'h7FFF_FFFF);
    expect_rise("R5", 49 - 11, 0);
    wr(4'h0, 32'h8000_0000);
    expect_rise("R6", 48 + 64, 1);
    chk("R6", "warn stays set", 32'(warn_irq), 32'h1);
    chk("R3", "rst_kind cpu", 32'(rst_kind), 32'd1);
    wr(4'h4, 32'hC000_0000);

    // R5: kick restarts the warning phase
    wr(4'h8, cfg(1, 0, 5, 7, 1));
    repeat (20) @(negedge clk);
    wr(4'h0, 32'h8000_0000);
    expect_rise("R5", 48, 0);
    wr(4'h8, cfg(1, 0, 5, 7, 1));
    repeat (70) @(negedge clk);
    wr(4'h4, 32'hC000_0000);

    // R7: disable halts, kick while off ignored, re-enable starts fresh
    wr(4'h8, cfg(1, 0, 3, 0, 1));
    repeat (20) @(negedge clk);
    wr(4'h8, cfg(0, 0, 3, 0, 1));
    repeat (3) @(negedge clk);
    wr(4'h0, 32'h8000_0000);
    repeat (60) @(negedge clk);
    chk("R7", "no warning while off", 32'(warn_irq), 32'h0);
    wr(4'h8, cfg(1, 0, 3, 0, 1));
    expect_rise("R7", 1 + 32, 0);
    expect_rise("R11", 8, 1);
    wr(4'h4, 32'hC000_0000);

    // R10: field readback, reserved bits, other offsets
    wr(4'h8, 32'h7FFF_FFFF);
    rd(4'h8, d); chk("R10", "ctrl readback", d, 32'h67CF_8003);
    rd(4'h0, d); chk("R10", "kick reads zero", d, 32'h0);
    rd(4'hC, d); chk("R10", "unused offset", d, 32'h0);
    wr(4'h8, 32'h0000_0001);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule